// File: doc/BRIEF.md
# Register Pointer with Snapshot Buffer

This block sits between a byte-level serial slave and the timekeeping registers of a real-time clock. The serial layer reports bus events to it: start, stop, an address byte with its direction bit, a written data byte, and acknowledgement that a read byte was taken. The block holds the register pointer, which picks one of ten locations. Locations 0 to 6 hold time, location 7 holds control, location 8 holds the charger setting and location 9 holds flags. The block turns each accepted data byte into a write strobe to that location and presents the read byte for the location under the pointer.

Time reads are served from a seven-byte snapshot rather than from the running counters. The snapshot is reloaded from the live time on a bus start, on a bus stop, and whenever the pointer steps onto location 0. A multibyte read therefore sees one coherent instant, even though the counters keep ticking.

A power gate blocks all host access while main power is bad. Access resumes only after power has been good for a set number of cycles. While access is blocked, every bus event is ignored.

The bus side is a four-state machine:
- BUS_IDLE waits for an address byte. A start or a stop always returns the machine here.
- The transition from BUS_IDLE to BUS_PTR happens on a write address. The first data byte in BUS_PTR loads the pointer and moves the machine to BUS_WR.
- In BUS_WR, every further data byte is written at the pointer.
- The transition to BUS_RD happens on a read address. In BUS_RD, each read acknowledgement advances the pointer.

The power side is a three-state machine:
- PWR_OFF moves to PWR_RECOVER while power is good.
- PWR_RECOVER counts the recovery cycles. It falls back to PWR_OFF if power drops, and moves to PWR_ON when the count completes.
- PWR_ON falls back to PWR_OFF when power drops.

Top module: `ptr_snapshot_regs`

## Requirements
- R1: After reset `cur_ptr` is 0, `access_ok` is 0, `reg_we` is 0 and `rbyte` is FFh.
- R2: `access_ok` rises exactly REC_CYCLES+1 rising edges after `pwr_good` is first driven high, counting the first edge that samples it high. `access_ok` falls in the same cycle that `pwr_good` falls, and is never 1 while `pwr_good` is 0.
- R3: The first data byte after a write-direction address loads the pointer and produces no write strobe. A loaded value of 10 or more sets the pointer to 0.
- R4: Each later data byte raises `reg_we` in its own cycle, with `reg_idx` equal to the pointer (the location number 0 to 9) and `reg_wdata` equal to the byte. The pointer then advances by one.
- R5: Advancing from location 7 gives location 0, so sequential access cycles through locations 0 to 7.
- R6: Advancing from location 8 gives 9, and advancing from 9 gives 0. Locations 8 and 9 are reached only by loading the pointer.
- R7: `rbyte` shows snapshot byte i for pointer i in 0 to 6; live_time byte i is bits [8i+7:8i]. For pointer 7, 8 and 9 it shows `ctrl_byte`, `chg_byte` and `flag_byte`. Each `rbyte_ack` in the read state advances the pointer.
- R8: The snapshot is reloaded from `live_time` on an accepted start, an accepted stop, or a pointer advance onto location 0. Changes to `live_time` at any other time do not show on `rbyte`.
- R9: While `access_ok` is 0, `rbyte` is FFh, no write strobe is raised, and start, stop, address and data events leave the pointer and the snapshot unchanged.
- R10: A read-direction address leaves the pointer unchanged, so a read begins at the location last loaded or reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Main power above the fail threshold |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| addr_valid | input | 1 | Address byte matched this device (pulse) |
| addr_rnw | input | 1 | Direction of the address byte, 1 = read |
| wbyte_valid | input | 1 | Data byte received from host (pulse) |
| wbyte | input | 8 | Received data byte |
| rbyte_ack | input | 1 | Read byte taken by host (pulse) |
| rbyte | output | 8 | Byte to transmit for the current pointer |
| live_time | input | 56 | Live time counters, byte i at [8i+7:8i] |
| ctrl_byte | input | 8 | Current control register value |
| chg_byte | input | 8 | Current charger setting value |
| flag_byte | input | 8 | Current flag register value |
| reg_we | output | 1 | Write strobe to the register at reg_idx |
| reg_idx | output | 4 | Location being written, 0 to 9 |
| reg_wdata | output | 8 | Data being written |
| cur_ptr | output | 4 | Current register pointer |
| access_ok | output | 1 | Host access currently allowed |

## Verification
The bench builds the block with REC_CYCLES set to 5 and keeps the default seven time bytes. The short recovery makes the exact edge on which access returns checkable within a few cycles, and lets the bench drop and restore power mid-run. With the default map, the wrap at location 7 is reached by both writes and reads, and the loaded-only wrap from location 9 is reached after a short pointer load. The bench changes `live_time` between events, so every refresh trigger can be seen to take effect and a non-trigger can be seen not to.

// File: rtl/ptr_snapshot_pkg.sv
package ptr_snapshot_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_PTR,
        BUS_WR,
        BUS_RD
    } bus_state_t;

    typedef enum logic [1:0] {
        PWR_OFF,
        PWR_RECOVER,
        PWR_ON
    } pwr_state_t;

endpackage

// File: rtl/ptr_pwr_gate.sv
module ptr_pwr_gate
    import ptr_snapshot_pkg::*;
#(
    parameter int REC_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic access_ok
);

    localparam int CNT_W = $clog2(REC_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYCLES - 1);

    pwr_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PWR_OFF: begin
                cnt_d = '0;
                if (pwr_good) state_d = PWR_RECOVER;
            end
            PWR_RECOVER: begin
                if (!pwr_good) begin
                    state_d = PWR_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = PWR_ON;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PWR_ON: begin
                if (!pwr_good) state_d = PWR_OFF;
            end
            default: state_d = PWR_OFF;
        endcase
    end

    assign access_ok = pwr_good && (state_q == PWR_ON);

endmodule

// File: rtl/ptr_shadow.sv
module ptr_shadow
    import ptr_snapshot_pkg::*;
#(
    parameter int TIME_LOCS = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          refresh,
    input  logic [TIME_LOCS*BYTE_W-1:0]   live_time,
    output logic [TIME_LOCS*BYTE_W-1:0]   shadow
);

    for (genvar i = 0; i < TIME_LOCS; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[i*BYTE_W +: BYTE_W] <= '0;
            end else if (refresh) begin
                shadow[i*BYTE_W +: BYTE_W] <= live_time[i*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/ptr_read_mux.sv
module ptr_read_mux
    import ptr_snapshot_pkg::*;
#(
    parameter int TIME_LOCS = 7,
    parameter int PTR_W     = 4
) (
    input  logic [PTR_W-1:0]              ptr,
    input  logic                          access_ok,
    input  logic [TIME_LOCS*BYTE_W-1:0]   shadow,
    input  logic [BYTE_W-1:0]             ctrl_byte,
    input  logic [BYTE_W-1:0]             chg_byte,
    input  logic [BYTE_W-1:0]             flag_byte,
    output logic [BYTE_W-1:0]             rbyte
);

    localparam logic [PTR_W-1:0] LOC_CTRL = PTR_W'(TIME_LOCS);
    localparam logic [PTR_W-1:0] LOC_CHG  = PTR_W'(TIME_LOCS + 1);
    localparam logic [PTR_W-1:0] LOC_FLAG = PTR_W'(TIME_LOCS + 2);

    always_comb begin
        rbyte = '1;
        if (access_ok) begin
            if (ptr < LOC_CTRL) begin
                rbyte = shadow[int'(ptr)*BYTE_W +: BYTE_W];
            end else if (ptr == LOC_CTRL) begin
                rbyte = ctrl_byte;
            end else if (ptr == LOC_CHG) begin
                rbyte = chg_byte;
            end else if (ptr == LOC_FLAG) begin
                rbyte = flag_byte;
            end
        end
    end

endmodule

// File: rtl/ptr_snapshot_regs.sv
module ptr_snapshot_regs
    import ptr_snapshot_pkg::*;
#(
    parameter int TIME_LOCS  = 7,
    parameter int REC_CYCLES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pwr_good,
    input  logic                          bus_start,
    input  logic                          bus_stop,
    input  logic                          addr_valid,
    input  logic                          addr_rnw,
    input  logic                          wbyte_valid,
    input  logic [7:0]                    wbyte,
    input  logic                          rbyte_ack,
    output logic [7:0]                    rbyte,
    input  logic [TIME_LOCS*8-1:0]        live_time,
    input  logic [7:0]                    ctrl_byte,
    input  logic [7:0]                    chg_byte,
    input  logic [7:0]                    flag_byte,
    output logic                          reg_we,
    output logic [$clog2(TIME_LOCS+3)-1:0] reg_idx,
    output logic [7:0]                    reg_wdata,
    output logic [$clog2(TIME_LOCS+3)-1:0] cur_ptr,
    output logic                          access_ok
);

    localparam int MAP_LOCS = TIME_LOCS + 3;
    localparam int PTR_W    = $clog2(MAP_LOCS);
    localparam logic [PTR_W-1:0] LOC_CTRL = PTR_W'(TIME_LOCS);
    localparam logic [PTR_W-1:0] LOC_LAST = PTR_W'(MAP_LOCS - 1);

    bus_state_t       st_q, st_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             refresh;
    logic [TIME_LOCS*BYTE_W-1:0] shadow_q;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        if (p == LOC_CTRL || p == LOC_LAST) return '0;
        return p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] load_ptr(input logic [BYTE_W-1:0] b);
        if (b < BYTE_W'(MAP_LOCS)) return b[PTR_W-1:0];
        return '0;
    endfunction

    ptr_pwr_gate #(.REC_CYCLES(REC_CYCLES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .access_ok (access_ok)
    );

    ptr_shadow #(.TIME_LOCS(TIME_LOCS)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .refresh   (refresh),
        .live_time (live_time),
        .shadow    (shadow_q)
    );

    ptr_read_mux #(.TIME_LOCS(TIME_LOCS), .PTR_W(PTR_W)) u_mux (
        .ptr       (ptr_q),
        .access_ok (access_ok),
        .shadow    (shadow_q),
        .ctrl_byte (ctrl_byte),
        .chg_byte  (chg_byte),
        .flag_byte (flag_byte),
        .rbyte     (rbyte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BUS_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        ptr_d     = ptr_q;
        refresh   = 1'b0;
        reg_we    = 1'b0;
        reg_idx   = ptr_q;
        reg_wdata = wbyte;
        if (access_ok) begin
            if (bus_start || bus_stop) begin
                st_d    = BUS_IDLE;
                refresh = 1'b1;
            end else if (addr_valid) begin
                st_d = addr_rnw ? BUS_RD : BUS_PTR;
            end else if (wbyte_valid) begin
                unique case (st_q)
                    BUS_PTR: begin
                        ptr_d = load_ptr(wbyte);
                        st_d  = BUS_WR;
                    end
                    BUS_WR: begin
                        reg_we  = 1'b1;
                        ptr_d   = step_ptr(ptr_q);
                        refresh = (step_ptr(ptr_q) == '0);
                    end
                    BUS_IDLE, BUS_RD: ;
                    default: st_d = BUS_IDLE;
                endcase
            end else if (rbyte_ack && st_q == BUS_RD) begin
                ptr_d   = step_ptr(ptr_q);
                refresh = (step_ptr(ptr_q) == '0);
            end
        end
    end

    assign cur_ptr = ptr_q;

endmodule

// File: rtl/ptr_snapshot_chk.sv
module ptr_snapshot_chk #(
    parameter int TIME_LOCS = 7,
    parameter int PTR_W     = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pwr_good,
    input logic                      bus_start,
    input logic                      access_ok,
    input logic [7:0]                rbyte,
    input logic                      reg_we,
    input logic [PTR_W-1:0]          reg_idx,
    input logic [PTR_W-1:0]          cur_ptr,
    input logic [TIME_LOCS*8-1:0]    live_time,
    input logic [TIME_LOCS*8-1:0]    shadow
);

    localparam logic [PTR_W-1:0] LOC_CTRL = PTR_W'(TIME_LOCS);
    localparam logic [PTR_W-1:0] LOC_LAST = PTR_W'(TIME_LOCS + 2);

    AST_PTR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ptr <= LOC_LAST); // R3

    AST_ACCESS_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> pwr_good); // R2

    AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx < LOC_CTRL) |=> cur_ptr == $past(reg_idx) + 1'b1); // R4

    AST_CTRL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == LOC_CTRL) |=> cur_ptr == '0); // R5

    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == LOC_LAST) |=> cur_ptr == '0); // R6

    AST_START_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && access_ok) |=> shadow == $past(live_time)); // R8

    AST_BLOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ok |-> !reg_we); // R9

    AST_BLOCK_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ok |-> rbyte == 8'hFF); // R9

    AST_BLOCK_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ok |=> (cur_ptr == $past(cur_ptr) && shadow == $past(shadow))); // R9

endmodule

bind ptr_snapshot_regs ptr_snapshot_chk #(
    .TIME_LOCS (TIME_LOCS),
    .PTR_W     (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .bus_start (bus_start),
    .access_ok (access_ok),
    .rbyte     (rbyte),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .cur_ptr   (cur_ptr),
    .live_time (live_time),
    .shadow    (shadow_q)
);

// File: tb/ptr_snapshot_regs_test.sv
module ptr_snapshot_regs_test;

    localparam int REC = 5;
    localparam int NV  = 34;
    localparam logic [2:0] OP_S = 3'd0, OP_P = 3'd1, OP_AW = 3'd2,
                           OP_AR = 3'd3, OP_W = 3'd4, OP_R = 3'd5;

    // {op, data, exp_we, exp_idx, exp_ptr, exp_rbyte}
    localparam logic [27:0] VEC [NV] = '{
        {OP_S,  8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_AW, 8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_W,  8'h03, 1'b0, 4'd0, 4'd3, 8'h13},
        {OP_W,  8'h55, 1'b1, 4'd3, 4'd4, 8'h14},
        {OP_W,  8'h66, 1'b1, 4'd4, 4'd5, 8'h15},
        {OP_P,  8'h00, 1'b0, 4'd0, 4'd5, 8'h15},
        {OP_S,  8'h00, 1'b0, 4'd0, 4'd5, 8'h15},
        {OP_AW, 8'h00, 1'b0, 4'd0, 4'd5, 8'h15},
        {OP_W,  8'h06, 1'b0, 4'd0, 4'd6, 8'h16},
        {OP_W,  8'h77, 1'b1, 4'd6, 4'd7, 8'hC7},
        {OP_W,  8'h88, 1'b1, 4'd7, 4'd0, 8'h10},
        {OP_S,  8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_AR, 8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd1, 8'h11},
        {OP_P,  8'h00, 1'b0, 4'd0, 4'd1, 8'h11},
        {OP_S,  8'h00, 1'b0, 4'd0, 4'd1, 8'h11},
        {OP_AW, 8'h00, 1'b0, 4'd0, 4'd1, 8'h11},
        {OP_W,  8'h08, 1'b0, 4'd0, 4'd8, 8'hA5},
        {OP_W,  8'h5A, 1'b1, 4'd8, 4'd9, 8'h80},
        {OP_W,  8'h00, 1'b1, 4'd9, 4'd0, 8'h10},
        {OP_S,  8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_AW, 8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_W,  8'h0C, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_S,  8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_AR, 8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd1, 8'h11},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd2, 8'h12},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd3, 8'h13},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd4, 8'h14},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd5, 8'h15},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd6, 8'h16},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd7, 8'hC7},
        {OP_R,  8'h00, 1'b0, 4'd0, 4'd0, 8'h10},
        {OP_P,  8'h00, 1'b0, 4'd0, 4'd0, 8'h10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0;
    logic        addr_valid = 1'b0, addr_rnw = 1'b0;
    logic        wbyte_valid = 1'b0, rbyte_ack = 1'b0;
    logic [7:0]  wbyte = 8'h00;
    logic [7:0]  rbyte;
    logic [55:0] live_time;
    logic [7:0]  ctrl_byte = 8'hC7, chg_byte = 8'hA5, flag_byte = 8'h80;
    logic        reg_we;
    logic [3:0]  reg_idx, cur_ptr;
    logic [7:0]  reg_wdata;
    logic        access_ok;

    logic        cap_we;
    logic [3:0]  cap_idx;
    logic [7:0]  cap_wdata;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ptr_snapshot_regs #(.TIME_LOCS(7), .REC_CYCLES(REC)) uut (
        .clk, .rst_n, .pwr_good, .bus_start, .bus_stop, .addr_valid,
        .addr_rnw, .wbyte_valid, .wbyte, .rbyte_ack, .rbyte, .live_time,
        .ctrl_byte, .chg_byte, .flag_byte, .reg_we, .reg_idx, .reg_wdata,
        .cur_ptr, .access_ok
    );

    task automatic set_live(input logic [7:0] base);
        for (int i = 0; i < 7; i++) live_time[i*8 +: 8] = base + 8'(i);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        bus_start   = (op == OP_S);
        bus_stop    = (op == OP_P);
        addr_valid  = (op == OP_AW) || (op == OP_AR);
        addr_rnw    = (op == OP_AR);
        wbyte_valid = (op == OP_W);
        rbyte_ack   = (op == OP_R);
        wbyte       = d;
        #1;
        cap_we = reg_we; cap_idx = reg_idx; cap_wdata = reg_wdata;
        @(negedge clk);
        bus_start = 0; bus_stop = 0; addr_valid = 0; addr_rnw = 0;
        wbyte_valid = 0; rbyte_ack = 0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        set_live(8'h10);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ptr", int'(cur_ptr), 0);
        chk("R1 access", int'(access_ok), 0);
        chk("R1 rbyte", int'(rbyte), 8'hFF);
        chk("R1 we", int'(reg_we), 0);

        do_op(OP_W, 8'h44);
        chk("R9 blocked we", int'(cap_we), 0);

        @(negedge clk);
        pwr_good = 1'b1;
        repeat (REC) @(posedge clk);
        @(negedge clk); #1;
        chk("R2 still recovering", int'(access_ok), 0);
        @(negedge clk); #1;
        chk("R2 access after recovery", int'(access_ok), 1);

        for (int k = 0; k < NV; k++) begin
            do_op(VEC[k][27:25], VEC[k][24:17]);
            chk("R4 R5 R6 R7 we", int'(cap_we), int'(VEC[k][16]));
            if (VEC[k][16]) begin
                chk("R4 idx", int'(cap_idx), int'(VEC[k][15:12]));
                chk("R4 wdata", int'(cap_wdata), int'(VEC[k][24:17]));
            end
            chk("R3 R5 R6 R7 ptr", int'(cur_ptr), int'(VEC[k][11:8]));
            chk("R7 rbyte", int'(rbyte), int'(VEC[k][7:0]));
        end

        do_op(OP_S, 8'h00);
        do_op(OP_AR, 8'h00);
        set_live(8'h30);
        #1;
        chk("R8 no refresh on live change", int'(rbyte), 8'h10);
        do_op(OP_R, 8'h00);
        chk("R8 no refresh mid read", int'(rbyte), 8'h11);
        do_op(OP_P, 8'h00);
        chk("R8 refresh on stop", int'(rbyte), 8'h31);

        do_op(OP_S, 8'h00);
        do_op(OP_AW, 8'h00);
        do_op(OP_W, 8'h07);
        do_op(OP_S, 8'h00);
        do_op(OP_AR, 8'h00);
        chk("R10 read keeps ptr", int'(cur_ptr), 7);
        set_live(8'h40);
        do_op(OP_R, 8'h00);
        chk("R8 wrap ptr", int'(cur_ptr), 0);
        chk("R8 refresh on wrap", int'(rbyte), 8'h40);

        do_op(OP_S, 8'h00);
        do_op(OP_AW, 8'h00);
        do_op(OP_W, 8'h05);
        do_op(OP_P, 8'h00);
        do_op(OP_S, 8'h00);
        do_op(OP_AR, 8'h00);
        chk("R10 ptr", int'(cur_ptr), 5);
        chk("R10 rbyte", int'(rbyte), 8'h45);

        @(negedge clk);
        pwr_good = 1'b0;
        #1;
        chk("R2 drop", int'(access_ok), 0);
        chk("R9 rbyte FF", int'(rbyte), 8'hFF);
        set_live(8'h50);
        do_op(OP_S, 8'h00);
        do_op(OP_AW, 8'h00);
        do_op(OP_W, 8'h02);
        do_op(OP_W, 8'h99);
        chk("R9 blocked write", int'(cap_we), 0);
        chk("R9 blocked ptr", int'(cur_ptr), 5);

        @(negedge clk);
        pwr_good = 1'b1;
        repeat (REC + 2) @(negedge clk);
        #1;
        chk("R2 restored", int'(access_ok), 1);
        chk("R9 ptr kept", int'(cur_ptr), 5);
        chk("R9 snapshot kept", int'(rbyte), 8'h45);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule